// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block tracks the coherence state of each line of a small direct-mapped private cache that holds one data word per line. Every line is in one of four states: Modified, Exclusive, Shared or Invalid. A processor port takes read and write requests. A hit finishes in the cycle it is presented. A miss, or a write to a line that other caches may also hold, is turned into a single bus transaction. That transaction is held on the bus until a completion strobe arrives.

A snoop port observes read, write and invalidate transactions issued by other caches on the shared bus. It reports in the same cycle, combinationally, whether this cache holds the addressed line. When dirty or sole-owner data must leave the cache, the snoop port supplies that data on a flush output. When memory holds stale data, it also drives a writeback. The line index is taken from the low address bits, and the stored tag is compared on both the processor path and the snoop path.

Top module: `coh_mesi_ctrl`

## Requirements
- R1: After reset every line is Invalid. No snoop gets a shared response or a flush, `bus_req` is low and `cpu_stall` is low.
- R2: A read that misses issues `bus_cmd`=1 (read). On the completing `bus_gnt` cycle, `cpu_rdata` equals `bus_fill_data`. The line fills as Shared if `bus_shared_in` is high in that cycle, and as Exclusive if it is low.
- R3: A write that misses issues `bus_cmd`=2 (read-for-ownership). When it completes, the line holds the written word in Modified.
- R4: A write to a Shared line issues `bus_cmd`=3 (upgrade). When it completes, the line is Modified and holds the written word.
- R5: A write to an Exclusive line completes in the cycle it is presented, with no bus request, and leaves the line Modified.
- R6: A read that hits a valid line, or a write that hits a Modified line, asserts `cpu_done` in the cycle it is presented, with no bus request. A read returns the stored word.
- R7: A snooped read (`snp_kind`=0) that hits an Exclusive line drives the data on `flush_data` with `flush_valid` and no writeback. If it hits a Modified line, it also drives `wb_valid` with `wb_addr`=`snp_addr`. Either way the line becomes Shared.
- R8: A snooped read that hits a Shared line drives no flush and leaves the line Shared. Any snoop that meets an Invalid line or a different tag has no effect.
- R9: A snooped write (`snp_kind`=1) or invalidate (`snp_kind`=2) turns a Shared or Exclusive line Invalid without a flush. A Modified line is first flushed and written back, then turns Invalid.
- R10: `snp_shared` is high exactly when a snooped read matches the tag of a line that is not Invalid.
- R11: A snoop takes precedence. While `snp_valid` is high, no local request completes or starts a bus transaction, and `bus_gnt` is ignored.
- R12: A miss whose indexed line holds another tag in Modified drives `wb_valid` for one cycle, in the cycle the miss is detected. That cycle carries the victim's address and data. Victims in other states are dropped silently.
- R13: `bus_req` stays high, with `bus_cmd` and `bus_addr` stable, until the grant completes. It falls in the cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Local request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Local word address (low bits index) |
| cpu_wdata | input | DATA_W | Local write word |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_stall | output | 1 | Request pending and not completing |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_done` |
| bus_req | output | 1 | Bus transaction pending |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-for-ownership, 3 upgrade |
| bus_addr | output | ADDR_W | Address of pending transaction |
| bus_gnt | input | 1 | Transaction completes this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (sampled with grant) |
| bus_fill_data | input | DATA_W | Fill word, sampled with grant |
| snp_valid | input | 1 | Snooped transaction present |
| snp_kind | input | 2 | 0 read, 1 write, 2 invalidate |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| flush_valid | output | 1 | Line data supplied to the bus |
| flush_data | output | DATA_W | Supplied word |
| wb_valid | output | 1 | Memory writeback this cycle |
| wb_addr | output | ADDR_W | Writeback address |
| wb_data | output | DATA_W | Writeback word |

## Verification
The bench visits every line index in each of the four states. In each state it applies every local and snooped operation, both on the matching tag and on a conflicting tag. It then reads the resulting state back through a snooped read, where the shared, flush and writeback pattern tells Shared, Exclusive and Modified apart. Three kinds of fault show up here:
- A controller that upgrades a Shared line silently exposes a stale copy.
- One that flushes from a clean line, or keeps a Modified line after a snooped write, shows the wrong flush or writeback pattern.
- One that misses the dirty-victim eviction loses data.

Directed cases cover a snoop and a local write to the same line in one cycle, and a grant that arrives together with a snoop. A controller that gave the local side priority would complete the write silently where a read-for-ownership is required, or would finish the transaction one cycle early.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  localparam logic [1:0] BC_NONE = 2'd0;
  localparam logic [1:0] BC_READ = 2'd1;
  localparam logic [1:0] BC_RFO  = 2'd2;
  localparam logic [1:0] BC_UPGR = 2'd3;

  localparam logic [1:0] SK_READ  = 2'd0;
  localparam logic [1:0] SK_WRITE = 2'd1;
  localparam logic [1:0] SK_INV   = 2'd2;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store import coh_pkg::*; #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  la_idx,
  output logic [TAG_W-1:0]  la_tag,
  output mesi_e             la_st,
  output logic [DATA_W-1:0] la_data,
  input  logic [IDX_W-1:0]  sa_idx,
  output logic [TAG_W-1:0]  sa_tag,
  output mesi_e             sa_st,
  output logic [DATA_W-1:0] sa_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  mesi_e             wr_st,
  input  logic              wr_tag_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data
);
  mesi_e             st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // state bits carry the reset; tag and data are qualified by state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else if (wr_en) begin
      st_q[wr_idx] <= wr_st;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_tag_en)  tag_q[wr_idx]  <= wr_tag;
    if (wr_en && wr_data_en) data_q[wr_idx] <= wr_data;
  end

  always_comb begin
    la_tag  = tag_q[la_idx];
    la_st   = st_q[la_idx];
    la_data = data_q[la_idx];
    sa_tag  = tag_q[sa_idx];
    sa_st   = st_q[sa_idx];
    sa_data = data_q[sa_idx];
  end
endmodule

// File: rtl/coh_snoop_dec.sv
module coh_snoop_dec import coh_pkg::*; #(
  parameter int TAG_W = 4
) (
  input  logic             snp_valid,
  input  logic [1:0]       snp_kind,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  mesi_e            line_st,
  output logic             shared_o,
  output logic             flush_o,
  output logic             wb_o,
  output logic             upd_o,
  output mesi_e            nxt_st_o
);
  logic hit;
  logic dirty;

  always_comb begin
    hit      = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
    dirty    = (line_st == ST_M);
    shared_o = 1'b0;
    flush_o  = 1'b0;
    wb_o     = 1'b0;
    upd_o    = 1'b0;
    nxt_st_o = line_st;
    case (snp_kind)
      SK_READ: begin
        shared_o = hit;
        flush_o  = hit && (line_st == ST_E || dirty);
        wb_o     = hit && dirty;
        upd_o    = hit && (line_st != ST_S);
        nxt_st_o = ST_S;
      end
      SK_WRITE, SK_INV: begin
        flush_o  = hit && dirty;
        wb_o     = hit && dirty;
        upd_o    = hit;
        nxt_st_o = ST_I;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm import coh_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       cpu_we,
  input  logic       snp_valid,
  input  logic       bus_gnt,
  input  logic       bus_shared_in,
  input  logic       line_match,
  input  mesi_e      line_st,
  output logic       busy_o,
  output logic [1:0] bus_cmd_o,
  output logic       cpu_done_o,
  output logic       bus_done_o,
  output logic       wr_en_o,
  output mesi_e      wr_st_o,
  output logic       wr_tag_en_o,
  output logic       wr_data_en_o,
  output logic       data_from_bus_o,
  output logic       evict_wb_o
);
  logic       busy_q, busy_d;
  logic [1:0] cmd_q, cmd_d;
  logic       line_hit, idle_go, hit_ok, go_bus, finish;

  always_comb begin
    line_hit = line_match && (line_st != ST_I);
    idle_go  = !busy_q && cpu_req && !snp_valid;
    hit_ok   = idle_go && line_hit && !(cpu_we && line_st == ST_S);
    go_bus   = idle_go && !hit_ok;
    finish   = busy_q && bus_gnt && !snp_valid;

    busy_d = busy_q;
    cmd_d  = cmd_q;
    if (go_bus) begin
      busy_d = 1'b1;
      cmd_d  = line_hit ? BC_UPGR : (cpu_we ? BC_RFO : BC_READ);
    end else if (finish) begin
      busy_d = 1'b0;
    end

    wr_en_o         = 1'b0;
    wr_st_o         = ST_I;
    wr_tag_en_o     = 1'b0;
    wr_data_en_o    = 1'b0;
    data_from_bus_o = 1'b0;
    evict_wb_o      = 1'b0;
    if (hit_ok && cpu_we) begin
      wr_en_o      = 1'b1;
      wr_st_o      = ST_M;
      wr_data_en_o = 1'b1;
    end else if (go_bus && !line_hit && line_st != ST_I) begin
      wr_en_o    = 1'b1;
      wr_st_o    = ST_I;
      evict_wb_o = (line_st == ST_M);
    end else if (finish) begin
      wr_en_o         = 1'b1;
      wr_tag_en_o     = 1'b1;
      wr_data_en_o    = 1'b1;
      data_from_bus_o = (cmd_q == BC_READ);
      if (cmd_q == BC_READ) wr_st_o = bus_shared_in ? ST_S : ST_E;
      else                  wr_st_o = ST_M;
    end

    busy_o     = busy_q;
    bus_cmd_o  = busy_q ? cmd_q : BC_NONE;
    cpu_done_o = hit_ok || finish;
    bus_done_o = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cmd_q  <= BC_NONE;
    end else begin
      busy_q <= busy_d;
      if (go_bus) cmd_q <= cmd_d;
    end
  end

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(bus_gnt && !snp_valid)) |=> (busy_o && $stable(bus_cmd_o)));

  // R11
  gnt_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_gnt && snp_valid) |=> busy_o);
endmodule

// File: rtl/coh_mesi_ctrl.sv
module coh_mesi_ctrl import coh_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic              cpu_stall,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_kind,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              flush_valid,
  output logic [DATA_W-1:0] flush_data,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag;
  logic [TAG_W-1:0]  la_tag, sa_tag;
  mesi_e             la_st, sa_st;
  logic [DATA_W-1:0] la_data, sa_data;

  logic  snp_flush, snp_wb, snp_upd;
  mesi_e snp_nxt;

  logic  busy, bus_done, l_wr_en, l_tag_en, l_data_en, l_from_bus, evict_wb;
  mesi_e l_wr_st;

  logic              wr_en, wr_tag_en, wr_data_en;
  logic [IDX_W-1:0]  wr_idx;
  mesi_e             wr_st;
  logic [DATA_W-1:0] wr_data;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk, .rst_n,
    .la_idx(cpu_idx), .la_tag, .la_st, .la_data,
    .sa_idx(snp_idx), .sa_tag, .sa_st, .sa_data,
    .wr_en, .wr_idx, .wr_st, .wr_tag_en, .wr_tag(cpu_tag),
    .wr_data_en, .wr_data
  );

  coh_snoop_dec #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid, .snp_kind, .snp_tag,
    .line_tag(sa_tag), .line_st(sa_st),
    .shared_o(snp_shared), .flush_o(snp_flush), .wb_o(snp_wb),
    .upd_o(snp_upd), .nxt_st_o(snp_nxt)
  );

  coh_req_fsm u_fsm (
    .clk, .rst_n, .cpu_req, .cpu_we, .snp_valid, .bus_gnt, .bus_shared_in,
    .line_match(la_tag == cpu_tag), .line_st(la_st),
    .busy_o(busy), .bus_cmd_o(bus_cmd), .cpu_done_o(cpu_done),
    .bus_done_o(bus_done), .wr_en_o(l_wr_en), .wr_st_o(l_wr_st),
    .wr_tag_en_o(l_tag_en), .wr_data_en_o(l_data_en),
    .data_from_bus_o(l_from_bus), .evict_wb_o(evict_wb)
  );

  // one write port: snoop updates and local updates never share a cycle
  always_comb begin
    if (snp_upd) begin
      wr_en      = 1'b1;
      wr_idx     = snp_idx;
      wr_st      = snp_nxt;
      wr_tag_en  = 1'b0;
      wr_data_en = 1'b0;
    end else begin
      wr_en      = l_wr_en;
      wr_idx     = cpu_idx;
      wr_st      = l_wr_st;
      wr_tag_en  = l_tag_en;
      wr_data_en = l_data_en;
    end
    wr_data = l_from_bus ? bus_fill_data : cpu_wdata;
  end

  always_comb begin
    cpu_stall   = cpu_req && !cpu_done;
    cpu_rdata   = (bus_done && !cpu_we) ? bus_fill_data : la_data;
    bus_req     = busy;
    bus_addr    = cpu_addr;
    flush_valid = snp_flush;
    flush_data  = sa_data;
    wb_valid    = snp_wb || evict_wb;
    wb_addr     = snp_wb ? snp_addr : {la_tag, cpu_idx};
    wb_data     = snp_wb ? sa_data : la_data;
  end

  // R11
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_done);

  // R10
  shared_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_shared |-> (snp_valid && snp_kind == SK_READ));

  // R7
  wb_with_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && wb_valid) |-> flush_valid);

  // R12
  evict_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !snp_valid) |-> (cpu_req && !cpu_done && !bus_req));

  // R13
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !snp_valid) |=> !bus_req);
endmodule

// File: tb/coh_mesi_ctrl_bench.sv
module coh_mesi_ctrl_bench;
  localparam int SI = 0, SS = 1, SE = 2, SM = 3;

  logic       clk, rst_n;
  logic       cpu_req, cpu_we;
  logic [5:0] cpu_addr;
  logic [7:0] cpu_wdata;
  logic       cpu_done, cpu_stall;
  logic [7:0] cpu_rdata;
  logic       bus_req;
  logic [1:0] bus_cmd;
  logic [5:0] bus_addr;
  logic       bus_gnt, bus_shared_in;
  logic [7:0] bus_fill_data;
  logic       snp_valid;
  logic [1:0] snp_kind;
  logic [5:0] snp_addr;
  logic       snp_shared, flush_valid, wb_valid;
  logic [7:0] flush_data, wb_data;
  logic [5:0] wb_addr;

  int nchk, nerr;
  int m_st [4];
  int m_tag [4];
  int m_data [4];
  bit done_flag;

  coh_mesi_ctrl u_coh_mesi_ctrl (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_done,
    .cpu_stall, .cpu_rdata, .bus_req, .bus_cmd, .bus_addr, .bus_gnt,
    .bus_shared_in, .bus_fill_data, .snp_valid, .snp_kind, .snp_addr,
    .snp_shared, .flush_valid, .flush_data, .wb_valid, .wb_addr, .wb_data
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string rq, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    end
  endtask

  task automatic lcl(bit we, int addr, int wd, bit shin, int fill);
    int idx = addr % 4;
    int tg = addr / 4;
    int st = m_st[idx];
    bit hit = (st != SI) && (m_tag[idx] == tg);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = 6'(addr); cpu_wdata = 8'(wd);
    #1;
    if (hit && (!we || st != SS)) begin
      string rq = (we && st == SE) ? "R5" : "R6";
      chk(rq, "done on hit", int'(cpu_done), 1);
      chk(rq, "no bus on hit", int'(bus_req), 0);
      if (!we) chk("R6", "read data", int'(cpu_rdata), m_data[idx]);
      if (we) begin m_st[idx] = SM; m_data[idx] = wd; end
      @(negedge clk);
      cpu_req = 1'b0;
      #1 chk(rq, "still no bus", int'(bus_req), 0);
    end else begin
      int cmd = hit ? 3 : (we ? 2 : 1);
      string rq = hit ? "R4" : (we ? "R3" : "R2");
      bit ev = !hit && (st == SM);
      chk(rq, "no early done", int'(cpu_done), 0);
      chk(rq, "stall", int'(cpu_stall), 1);
      chk("R12", "evict wb", int'(wb_valid), int'(ev));
      if (ev) begin
        chk("R12", "evict addr", int'(wb_addr), m_tag[idx] * 4 + idx);
        chk("R12", "evict data", int'(wb_data), m_data[idx]);
      end
      if (!hit) m_st[idx] = SI;
      @(negedge clk); #1;
      chk(rq, "bus req", int'(bus_req), 1);
      chk(rq, "bus cmd", int'(bus_cmd), cmd);
      chk("R13", "bus addr", int'(bus_addr), addr);
      chk("R12", "wb one cycle", int'(wb_valid), 0);
      @(negedge clk); #1;
      chk("R13", "req held", int'(bus_req), 1);
      chk("R13", "cmd held", int'(bus_cmd), cmd);
      bus_gnt = 1'b1; bus_shared_in = shin; bus_fill_data = 8'(fill);
      #1;
      chk(rq, "done on grant", int'(cpu_done), 1);
      if (!we) chk("R2", "fill data", int'(cpu_rdata), fill);
      m_tag[idx]  = tg;
      m_st[idx]   = we ? SM : (shin ? SS : SE);
      m_data[idx] = we ? wd : fill;
      @(negedge clk);
      cpu_req = 1'b0; bus_gnt = 1'b0; bus_shared_in = 1'b0;
      #1 chk("R13", "req dropped", int'(bus_req), 0);
    end
  endtask

  task automatic snp(int kind, int addr);
    int idx = addr % 4;
    int st = m_st[idx];
    bit hit = (st != SI) && (m_tag[idx] == addr / 4);
    bit e_sh, e_fl, e_wb;
    string rq;
    e_sh = (kind == 0) && hit;
    e_fl = hit && (st == SM || (kind == 0 && st == SE));
    e_wb = hit && st == SM;
    if (kind == 0) rq = (hit && st != SS) ? "R7" : "R8";
    else rq = hit ? "R9" : "R8";
    @(negedge clk);
    snp_valid = 1'b1; snp_kind = 2'(kind); snp_addr = 6'(addr);
    #1;
    chk("R10", "shared resp", int'(snp_shared), int'(e_sh));
    chk(rq, "flush", int'(flush_valid), int'(e_fl));
    chk(rq, "writeback", int'(wb_valid), int'(e_wb));
    if (e_fl) chk(rq, "flush data", int'(flush_data), m_data[idx]);
    if (e_wb) chk(rq, "wb addr", int'(wb_addr), addr);
    if (hit) m_st[idx] = (kind == 0) ? SS : SI;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  initial begin
    nchk = 0; nerr = 0; done_flag = 1'b0;
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    bus_gnt = 1'b0; bus_shared_in = 1'b0; bus_fill_data = '0;
    snp_valid = 1'b0; snp_kind = '0; snp_addr = '0;
    for (int i = 0; i < 4; i++) begin m_st[i] = SI; m_tag[i] = 0; m_data[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "bus idle", int'(bus_req), 0);
    chk("R1", "no stall", int'(cpu_stall), 0);
    for (int i = 0; i < 4; i++) snp(0, i);

    // R11: grant ignored while a snoop is present
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 6'd9;
    @(negedge clk); #1;
    chk("R11", "req before grant", int'(bus_req), 1);
    bus_gnt = 1'b1; bus_fill_data = 8'h3C; snp_valid = 1'b1; snp_kind = 2'd0; snp_addr = 6'd2;
    #1 chk("R11", "grant deferred", int'(cpu_done), 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1 chk("R11", "grant after snoop", int'(cpu_done), 1);
    @(negedge clk);
    cpu_req = 1'b0; bus_gnt = 1'b0;
    m_st[1] = SE; m_tag[1] = 2; m_data[1] = 8'h3C;

    // R11: snoop and local write to the same Exclusive line in one cycle
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 6'd9; cpu_wdata = 8'h77;
    snp_valid = 1'b1; snp_kind = 2'd2; snp_addr = 6'd9;
    #1;
    chk("R11", "local held off", int'(cpu_done), 0);
    chk("R11", "no flush from E", int'(flush_valid), 0);
    @(negedge clk);
    cpu_req = 1'b0; snp_valid = 1'b0;
    #1 chk("R11", "no bus started", int'(bus_req), 0);
    m_st[1] = SI;
    lcl(1'b1, 9, 8'h77, 1'b0, 0);
    snp(0, 9);

    // sweep: every line, every start state, every operation, both tags
    for (int idx = 0; idx < 4; idx++)
      for (int st = 0; st < 4; st++)
        for (int op = 0; op < 5; op++)
          for (int alt = 0; alt < 2; alt++) begin
            int ta = (idx * 3 + 1) % 16;
            int tb = ta ^ 8;
            int aa = ta * 4 + idx;
            int ab = tb * 4 + idx;
            int fill = (idx * 16 + st * 4 + op + alt * 64 + 1) & 255;
            int wd = fill ^ 8'hA5;
            int oa = alt ? ab : aa;
            snp(2, aa);
            if (st != SI) lcl(1'b0, aa, 0, st == SS, fill);
            if (st == SM) lcl(1'b1, aa, wd ^ 8'h0F, 1'b0, 0);
            case (op)
              0: lcl(1'b0, oa, 0, alt[0], fill ^ 8'h11);
              1: lcl(1'b1, oa, wd, 1'b0, 0);
              2: snp(0, oa);
              3: snp(1, oa);
              default: snp(2, oa);
            endcase
            snp(0, m_tag[idx] * 4 + idx);
          end

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end
endmodule